// File: doc/BRIEF.md
# Descriptor Channel Control Sequencer

This block is the control state machine of one scatter-gather DMA channel. It holds the source and destination start pointers, given as inputs, and the current descriptor pointers derived from them. Software drives it with writes that carry an enable bit, a continue bit and a continue-address bit. While a channel runs, the block fetches descriptors through a memory request port with a valid/ready handshake and a separate response. For each source descriptor it starts one transfer on a separate data mover and waits for that mover to report completion.

When a transfer completes, the block acts on the command field of the current source descriptor. It can stop the channel, pause it, or move on to the next descriptor. The next descriptor is either the one that directly follows in memory, or the one named by a link pointer that the block reads from memory. Descriptors can also come from registers. In that case the channel carries out a single transfer and then disables itself.

Errors are reported on the state output, which reads 3 while the error flag is set, and on one-cycle interrupt pulses.

Top module: `dma_desc_seq`

## Requirements
- R1: The `state` output reads 0 when disabled, 1 when enabled and 2 when paused. It reads 3 whenever the error flag is set. After reset, `state` is 0, `en_bit` is 0, and neither `mem_req_valid` nor `xfer_go` is asserted.
- R2: A write with enable 1 while disabled clears the error flag and copies both start pointers into the current pointers. In memory mode it then requests the destination descriptor (kind 0, at the destination pointer) before the source descriptor (kind 1, at the source pointer).
- R3: A write with enable 1 and continue 1 while paused resumes the channel and clears the continue bit. With continue-address 1 it reloads both start pointers and refetches the destination descriptor. With continue-address 0 it moves on to the next source descriptor.
- R4: A write with enable 0 and continue 1 while paused enters disabled. A write with continue 0 while paused changes nothing.
- R5: The command field is bits 4..3 of descriptor word 3, returned in response bits 4..3. When the transfer completes, command 1 enters paused and pulses `irq_pause`. Command 2 clears the enable bit and enters disabled. Commands 0 and 3 go on to the next descriptor.
- R6: With `ptr_mem` 0 (descriptors taken from registers), enabling performs exactly one transfer and issues no memory request. The channel then clears the enable bit and disables.
- R7: A descriptor address whose low 4 bits are not all zero is never requested. The block sets the error flag, pulses `irq_src_err` or `irq_dst_err` for the side concerned, and disables the channel.
- R8: The type bit is bit 1 of descriptor word 3. Type 0 (linear) makes the next source pointer the current pointer plus 16. Type 1 (linked) issues a kind-2 read at the current pointer plus 16, and the response bits 48..0 become the next pointer. All addresses are 49 bits wide.
- R9: A memory request that is not accepted keeps `mem_req_valid`, its address and its kind unchanged until `mem_req_ready` is seen.
- R10: A control write that arrives while a memory access is outstanding is held. It takes effect only after the response has been handled, so `en_bit` and `state` stay unchanged until then.
- R11: Each source descriptor fetched causes exactly one transfer: `xfer_go` is held until `xfer_done`. `xfer_go` and `mem_req_valid` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_mem | input | 1 | 1: descriptors fetched from memory, 0: taken from registers |
| src_start | input | 49 | Source start descriptor pointer |
| dst_start | input | 49 | Destination start descriptor pointer |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the write |
| ctl_cont | input | 1 | Continue bit of the write |
| ctl_cont_addr | input | 1 | Continue-address bit: 1 restarts from the start pointers |
| en_bit | output | 1 | Current enable bit |
| cont_bit | output | 1 | Current continue bit |
| state | output | 2 | Channel state |
| src_cur | output | 49 | Current source descriptor pointer |
| dst_cur | output | 49 | Current destination descriptor pointer |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 49 | Memory read address |
| mem_req_kind | output | 2 | 0 destination descriptor, 1 source descriptor, 2 link pointer |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 49 | Descriptor word 3, or the link pointer |
| xfer_go | output | 1 | Start of a transfer on the data mover |
| xfer_done | input | 1 | Data mover reports that the transfer is complete |
| irq_pause | output | 1 | Pulse when the channel pauses on command 1 |
| irq_src_err | output | 1 | Pulse on a misaligned source descriptor address |
| irq_dst_err | output | 1 | Pulse on a misaligned destination descriptor address |

## Verification
The bench runs descriptor chains from a table of cases. The cases cover an immediate stop, a linear walk of three descriptors, a halt, a linked jump, and both a misaligned start and a misaligned link target. Together they separate linear stepping from link following, pausing from stopping, and error handling at the start of a chain from error handling in the middle of one. Directed cases test the two ways of resuming by moving the start pointer between the pause and the resume. They also cover leaving the paused state without enabling, register mode, a misaligned destination pointer followed by error recovery, and a write held behind a stalled request.

// File: rtl/dma_desc_seq.sv
module dma_desc_seq #(
  parameter int AW         = 49,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_mem,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic          ctl_cont,
  input  logic          ctl_cont_addr,
  output logic          en_bit,
  output logic          cont_bit,
  output logic [1:0]    state,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_kind,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          xfer_go,
  input  logic          xfer_done,
  output logic          irq_pause,
  output logic          irq_src_err,
  output logic          irq_dst_err
);

  localparam int            OFS  = $clog2(DESC_BYTES);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  typedef enum logic [1:0] {ST_DIS = 2'd0, ST_EN = 2'd1, ST_PAU = 2'd2} st_e;
  typedef enum logic [2:0] {PH_IDLE, PH_DREQ, PH_DRSP, PH_SREQ, PH_SRSP,
                            PH_XFER, PH_LREQ, PH_LRSP} ph_e;

  st_e           st_q;
  ph_e           ph_q;
  logic          err_q, en_q, cont_q, typ_q;
  logic [1:0]    cmd_q;
  logic [AW-1:0] src_q, dst_q;
  logic          pend_q, pend_en, pend_cont, pend_ca;
  logic          irq_p_q, irq_s_q, irq_d_q;

  logic busy, wr_now, w_en, w_cont, w_ca, misal_d, misal_s;

  assign busy    = ph_q inside {PH_DREQ, PH_DRSP, PH_SREQ, PH_SRSP, PH_LREQ, PH_LRSP};
  assign wr_now  = !busy && (ctl_wr || pend_q);
  assign w_en    = ctl_wr ? ctl_en        : pend_en;
  assign w_cont  = ctl_wr ? ctl_cont      : pend_cont;
  assign w_ca    = ctl_wr ? ctl_cont_addr : pend_ca;
  assign misal_d = dst_q[OFS-1:0] != '0;
  assign misal_s = src_q[OFS-1:0] != '0;

  assign mem_req_valid = (ph_q == PH_DREQ && !misal_d) || (ph_q == PH_SREQ && !misal_s) ||
                         (ph_q == PH_LREQ);
  assign mem_req_addr  = (ph_q == PH_DREQ) ? dst_q : (ph_q == PH_LREQ) ? src_q + STEP : src_q;
  assign mem_req_kind  = (ph_q == PH_DREQ) ? 2'd0 : (ph_q == PH_LREQ) ? 2'd2 : 2'd1;
  assign xfer_go       = ph_q == PH_XFER;

  assign state       = err_q ? 2'd3 : st_q;
  assign en_bit      = en_q;
  assign cont_bit    = cont_q;
  assign src_cur     = src_q;
  assign dst_cur     = dst_q;
  assign irq_pause   = irq_p_q;
  assign irq_src_err = irq_s_q;
  assign irq_dst_err = irq_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_DIS;  ph_q <= PH_IDLE;
      err_q <= 1'b0;   en_q <= 1'b0;  cont_q <= 1'b0;
      typ_q <= 1'b0;   cmd_q <= 2'd0;
      src_q <= '0;     dst_q <= '0;
      pend_q <= 1'b0;  pend_en <= 1'b0; pend_cont <= 1'b0; pend_ca <= 1'b0;
      irq_p_q <= 1'b0; irq_s_q <= 1'b0; irq_d_q <= 1'b0;
    end else begin
      irq_p_q <= 1'b0;
      irq_s_q <= 1'b0;
      irq_d_q <= 1'b0;

      if (busy && ctl_wr) begin
        pend_q    <= 1'b1;
        pend_en   <= ctl_en;
        pend_cont <= ctl_cont;
        pend_ca   <= ctl_cont_addr;
      end

      if (wr_now) begin
        pend_q <= 1'b0;
        en_q   <= w_en;
        cont_q <= w_cont;
        if (w_en) begin
          err_q <= 1'b0;
          if (st_q == ST_PAU && w_cont) begin
            cont_q <= 1'b0;
            st_q   <= ST_EN;
            if (w_ca) begin
              src_q <= src_start;
              dst_q <= dst_start;
              ph_q  <= PH_DREQ;
            end else if (typ_q) begin
              ph_q <= PH_LREQ;
            end else begin
              src_q <= src_q + STEP;
              ph_q  <= PH_SREQ;
            end
          end else if (st_q == ST_DIS) begin
            src_q <= src_start;
            dst_q <= dst_start;
            st_q  <= ST_EN;
            ph_q  <= ptr_mem ? PH_DREQ : PH_XFER;
          end
        end else if (st_q == ST_PAU && w_cont) begin
          st_q <= ST_DIS;
        end
      end

      case (ph_q)
        PH_DREQ: begin
          if (misal_d) begin
            err_q <= 1'b1; irq_d_q <= 1'b1; st_q <= ST_DIS; ph_q <= PH_IDLE;
          end else if (mem_req_ready) begin
            ph_q <= PH_DRSP;
          end
        end
        PH_DRSP: if (mem_rsp_valid) ph_q <= PH_SREQ;
        PH_SREQ: begin
          if (misal_s) begin
            err_q <= 1'b1; irq_s_q <= 1'b1; st_q <= ST_DIS; ph_q <= PH_IDLE;
          end else if (mem_req_ready) begin
            ph_q <= PH_SRSP;
          end
        end
        PH_SRSP: begin
          if (mem_rsp_valid) begin
            cmd_q <= mem_rsp_data[4:3];
            typ_q <= mem_rsp_data[1];
            ph_q  <= PH_XFER;
          end
        end
        PH_XFER: begin
          if (xfer_done) begin
            if (!ptr_mem || cmd_q == 2'd2) begin
              en_q <= 1'b0; st_q <= ST_DIS; ph_q <= PH_IDLE;
            end else if (cmd_q == 2'd1) begin
              st_q <= ST_PAU; irq_p_q <= 1'b1; ph_q <= PH_IDLE;
            end else if (typ_q) begin
              ph_q <= PH_LREQ;
            end else begin
              src_q <= src_q + STEP;
              ph_q  <= PH_SREQ;
            end
          end
        end
        PH_LREQ: if (mem_req_ready) ph_q <= PH_LRSP;
        PH_LRSP: begin
          if (mem_rsp_valid) begin
            src_q <= mem_rsp_data;
            ph_q  <= PH_SREQ;
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_kind));

  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_kind != 2'd2 |-> mem_req_addr[OFS-1:0] == '0);

  // R11
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_go && mem_req_valid));

  // R5
  pause_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pause |-> state == 2'd2);

  // R7
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src_err || irq_dst_err |-> state == 2'd3);

  // R10
  held_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(en_bit) && $stable(state));

endmodule

// File: tb/dma_desc_seq_bench.sv
module dma_desc_seq_bench;
  localparam int AW = 49;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ptr_mem = 1'b1;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic          ctl_wr = 1'b0, ctl_en = 1'b0, ctl_cont = 1'b0, ctl_cont_addr = 1'b0;
  logic          en_bit, cont_bit;
  logic [1:0]    state;
  logic [AW-1:0] src_cur, dst_cur, mem_req_addr;
  logic          mem_req_valid, mem_req_ready;
  logic [1:0]    mem_req_kind;
  logic          mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic          xfer_go, xfer_done;
  logic          irq_pause, irq_src_err, irq_dst_err;

  logic          hold_ready = 1'b0;
  logic [2:0]    slot_ctl [4];
  logic [AW-1:0] link_val = '0;
  logic          done_r = 1'b0;
  int cnt_x = 0, cnt_p = 0, cnt_se = 0, cnt_de = 0, cnt_req = 0, cnt_dreq = 0;
  logic [AW-1:0] log_addr [8];
  logic [1:0]    log_kind [8];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  assign mem_req_ready = ~hold_ready;
  assign xfer_done     = done_r;

  dma_desc_seq u_dma_desc_seq (
    .clk(clk), .rst_n(rst_n), .ptr_mem(ptr_mem), .src_start(src_start), .dst_start(dst_start),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_cont(ctl_cont), .ctl_cont_addr(ctl_cont_addr),
    .en_bit(en_bit), .cont_bit(cont_bit), .state(state), .src_cur(src_cur), .dst_cur(dst_cur),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_kind(mem_req_kind), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xfer_go(xfer_go), .xfer_done(xfer_done), .irq_pause(irq_pause),
    .irq_src_err(irq_src_err), .irq_dst_err(irq_dst_err));

  // memory and mover models; word 3: cmd at bits 4..3, type at bit 1
  always @(posedge clk) begin
    logic [2:0] c;
    c = slot_ctl[mem_req_addr[5:4]];
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= (mem_req_kind == 2'd2) ? link_val : {44'b0, c[1:0], 1'b0, c[2], 1'b0};
      log_addr[cnt_req % 8] <= mem_req_addr;
      log_kind[cnt_req % 8] <= mem_req_kind;
      cnt_req <= cnt_req + 1;
      if (mem_req_kind == 2'd0) cnt_dreq <= cnt_dreq + 1;
    end
    done_r <= xfer_go && !done_r;
    if (xfer_go && done_r) cnt_x <= cnt_x + 1;
    if (irq_pause)   cnt_p  <= cnt_p + 1;
    if (irq_src_err) cnt_se <= cnt_se + 1;
    if (irq_dst_err) cnt_de <= cnt_de + 1;
  end

  // {src[8], slot0..3 {type,cmd}, link[8], exp_state[2], exp_src[8], exp_xfers[4], exp_pause}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {8'h00, 3'b010, 3'b010, 3'b010, 3'b010, 8'h00, 2'd0, 8'h00, 4'd1, 1'b0},
    {8'h00, 3'b000, 3'b000, 3'b010, 3'b010, 8'h00, 2'd0, 8'h20, 4'd3, 1'b0},
    {8'h00, 3'b001, 3'b010, 3'b010, 3'b010, 8'h00, 2'd2, 8'h00, 4'd1, 1'b1},
    {8'h00, 3'b100, 3'b000, 3'b000, 3'b010, 8'h30, 2'd0, 8'h30, 4'd2, 1'b0},
    {8'h08, 3'b010, 3'b010, 3'b010, 3'b010, 8'h00, 2'd3, 8'h08, 4'd0, 1'b0},
    {8'h00, 3'b100, 3'b010, 3'b010, 3'b010, 8'h24, 2'd3, 8'h24, 4'd1, 1'b0},
    {8'h10, 3'b010, 3'b000, 3'b001, 3'b010, 8'h00, 2'd2, 8'h20, 4'd2, 1'b1}
  };

  int s_x, s_p, s_se, s_de, s_req, s_dreq;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ctl_wr = 1'b0; hold_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic snap();
    s_x = cnt_x; s_p = cnt_p; s_se = cnt_se; s_de = cnt_de; s_req = cnt_req; s_dreq = cnt_dreq;
  endtask

  task automatic wr(input logic en, input logic cont, input logic ca);
    ctl_en = en; ctl_cont = cont; ctl_cont_addr = ca; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (state != 2'd1) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic set_slots(input logic [2:0] a, input logic [2:0] b,
                           input logic [2:0] c, input logic [2:0] d);
    slot_ctl[0] = a; slot_ctl[1] = b; slot_ctl[2] = c; slot_ctl[3] = d;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    set_slots(3'b010, 3'b010, 3'b010, 3'b010);
    do_reset();
    chk("R1 reset state", state, 0);
    chk("R1 reset en_bit", en_bit, 0);
    chk("R1 reset mem_req_valid", mem_req_valid, 0);
    chk("R1 reset xfer_go", xfer_go, 0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      do_reset();
      ptr_mem = 1'b1;
      src_start = {41'b0, v[42:35]};
      dst_start = 49'h40;
      set_slots(v[34:32], v[31:29], v[28:26], v[25:23]);
      link_val = {41'b0, v[22:15]};
      snap();
      wr(1, 0, 0);
      settle();
      chk($sformatf("R5 vec%0d state", i), state, v[14:13]);
      chk($sformatf("R8 vec%0d src_cur", i), src_cur, {41'b0, v[12:5]});
      chk($sformatf("R11 vec%0d transfers", i), cnt_x - s_x, v[4:1]);
      chk($sformatf("R5 vec%0d pause irq", i), cnt_p - s_p, v[0]);
      if (v[14:13] == 2'd3) chk($sformatf("R7 vec%0d src err irq", i), cnt_se - s_se, 1);
      if (v[14:13] == 2'd0) chk($sformatf("R5 vec%0d en cleared", i), en_bit, 0);
    end

    // R2: start pointers copied, destination fetched before source, 49-bit address
    do_reset();
    set_slots(3'b010, 3'b010, 3'b010, 3'b010);
    src_start = 49'h1_0000_0000_0000;
    dst_start = 49'h1_2345_0000_0040;
    snap();
    wr(1, 0, 0);
    settle();
    chk("R2 dst_cur", dst_cur, 49'h1_2345_0000_0040);
    chk("R2 first request kind", log_kind[s_req % 8], 0);
    chk("R2 first request addr", log_addr[s_req % 8], 49'h1_2345_0000_0040);
    chk("R2 second request kind", log_kind[(s_req + 1) % 8], 1);
    chk("R2 second request addr", log_addr[(s_req + 1) % 8], 49'h1_0000_0000_0000);

    // R3: resume with continue-address 0 moves to next descriptor
    do_reset();
    set_slots(3'b001, 3'b010, 3'b010, 3'b010);
    src_start = 49'h0; dst_start = 49'h40;
    snap();
    wr(1, 0, 0);
    settle();
    chk("R3 paused before resume", state, 2);
    wr(1, 1, 0);
    settle();
    chk("R3 next-descriptor resume state", state, 0);
    chk("R3 next-descriptor src_cur", src_cur, 49'h10);
    chk("R3 next-descriptor transfers", cnt_x - s_x, 2);
    chk("R3 continue bit self-clears", cont_bit, 0);

    // R3: resume with continue-address 1 reloads start pointers
    do_reset();
    set_slots(3'b001, 3'b010, 3'b010, 3'b010);
    src_start = 49'h0;
    snap();
    wr(1, 0, 0);
    settle();
    src_start = 49'h20;
    wr(1, 1, 1);
    settle();
    chk("R3 reload src_cur", src_cur, 49'h20);
    chk("R3 reload state", state, 0);
    chk("R3 reload dst descriptor fetches", cnt_dreq - s_dreq, 2);

    // R4: leaving pause without enable
    do_reset();
    set_slots(3'b001, 3'b010, 3'b010, 3'b010);
    src_start = 49'h0;
    wr(1, 0, 0);
    settle();
    wr(0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R4 continue 0 keeps paused", state, 2);
    wr(0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R4 continue 1 disables", state, 0);

    // R6: register mode
    do_reset();
    ptr_mem = 1'b0;
    snap();
    wr(1, 0, 0);
    settle();
    chk("R6 register mode transfers", cnt_x - s_x, 1);
    chk("R6 register mode no requests", cnt_req - s_req, 0);
    chk("R6 register mode state", state, 0);
    chk("R6 register mode en cleared", en_bit, 0);
    ptr_mem = 1'b1;

    // R7: misaligned destination, then R2 error cleared by enable
    do_reset();
    set_slots(3'b010, 3'b010, 3'b010, 3'b010);
    src_start = 49'h0; dst_start = 49'h48;
    snap();
    wr(1, 0, 0);
    settle();
    chk("R7 dst misaligned state", state, 3);
    chk("R7 dst err irq", cnt_de - s_de, 1);
    chk("R7 dst misaligned no transfer", cnt_x - s_x, 0);
    dst_start = 49'h40;
    snap();
    wr(1, 0, 0);
    settle();
    chk("R2 error cleared by enable", state, 0);
    chk("R2 recovery transfers", cnt_x - s_x, 1);

    // R10/R9: write held behind a stalled request
    do_reset();
    set_slots(3'b001, 3'b010, 3'b010, 3'b010);
    src_start = 49'h0; dst_start = 49'h40;
    hold_ready = 1'b1;
    wr(1, 0, 0);
    wr(0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R10 held write en_bit", en_bit, 1);
    chk("R10 held write cont_bit", cont_bit, 0);
    chk("R10 held write state", state, 1);
    chk("R9 request addr held", mem_req_addr, 49'h40);
    chk("R9 request valid held", mem_req_valid, 1);
    hold_ready = 1'b0;
    settle();
    chk("R10 write applied after response en_bit", en_bit, 0);
    chk("R10 write applied after response cont_bit", cont_bit, 1);

    summary();
    $finish;
  end
endmodule